// File: doc/BRIEF.md
# External Memory Interface Sequencer

This block sits between a processor core and one shared external bus with 16-bit address and 16-bit data. The core has two request ports. The X port carries instruction and coefficient accesses, and every X request goes to the external program memory segment. The Y port carries data accesses. Each Y address is decoded: low addresses belong to on-chip RAM or to a reserved range and start no external cycle. All other Y addresses select one of three external data segments. Each active segment drives its own active-low enable.

The length of every external cycle depends on its segment. It is a base of two clocks plus a wait count of 0 to 15 clocks, taken from a 16-bit wait register. When one instruction requests external accesses on both ports, the X access runs first and the Y access follows directly after it. The block holds the core with a stall output until the last access is finished. Read data comes back on a shared bus with one valid pulse per port. For a write, the data bus is driven from the second clock of the cycle onward. After a write the data stays on the bus until a read cycle begins.

Top module: `emi_sequencer`

## Requirements
- R1: After reset, all four segment enables are high, `ext_rwn` is high, `ext_doe` is low, `stall` is low, and the wait register holds 0xFFFF.
- R2: A Y request to 0x4000–0x40FF drives `seg_io_n` low. A Y request to 0x4100–0x7FFF drives `seg_lo_n` low. A Y request to 0x8000–0xFFFF drives `seg_hi_n` low. Each enable covers only its own cycle, and `ext_addr` carries the request address during that cycle.
- R3: A Y request below 0x4000 starts no external cycle and raises no stall.
- R4: Every X request runs an external cycle with `seg_rom_n` low.
- R5: An external cycle lasts 2 + W clocks. W is the segment's field in the wait register: [3:0] for the 0x4100–0x7FFF segment, [7:4] for the I/O segment, [11:8] for the 0x8000–0xFFFF segment and [15:12] for X accesses. The register is loaded from `cfg_wdata` on a clock where `cfg_we` is high.
- R6: When X and Y both request external accesses, the X cycle runs first and the Y cycle starts on the clock right after the X cycle ends. Each cycle uses its own segment's wait count.
- R7: `ext_rwn` is low on every clock of a write cycle and high at all other times.
- R8: In a write cycle, `ext_doe` is high and `ext_dout` equals the write data from the second clock of the cycle onward.
- R9: After a write, `ext_doe` stays high and `ext_dout` keeps the written value through idle clocks and through a following write's first clock. `ext_doe` is low on every clock of a read cycle.
- R10: `stall` is high from the request clock until the final clock of the last access, and low on that final clock. For an instruction with external accesses, the number of stalled clocks equals the sum of the cycle lengths.
- R11: A read samples `ext_din` on the last clock of its cycle. The next clock presents the value on `rd_data`, with a one-clock pulse on `x_rvalid` or `y_rvalid` for the port that made the request.
- R12: At most one segment enable is low on any clock, and all are high while no external cycle runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the wait register |
| cfg_wdata | input | 16 | New wait register value |
| x_req | input | 1 | X port external request, held while stalled |
| x_we | input | 1 | X request is a write |
| x_addr | input | 16 | X request address |
| x_wdata | input | 16 | X write data |
| y_req | input | 1 | Y port request, held while stalled |
| y_we | input | 1 | Y request is a write |
| y_addr | input | 16 | Y request address |
| y_wdata | input | 16 | Y write data |
| stall | output | 1 | Holds the core while external accesses are outstanding |
| rd_data | output | 16 | Returned read data |
| x_rvalid | output | 1 | rd_data belongs to the X port |
| y_rvalid | output | 1 | rd_data belongs to the Y port |
| ext_addr | output | 16 | External address bus |
| ext_dout | output | 16 | External write data |
| ext_doe | output | 1 | External data bus drive enable |
| ext_din | input | 16 | External read data |
| ext_rwn | output | 1 | High for read, low for write |
| seg_lo_n | output | 1 | Enable for data addresses 0x4100–0x7FFF, active low |
| seg_io_n | output | 1 | Enable for I/O addresses 0x4000–0x40FF, active low |
| seg_hi_n | output | 1 | Enable for data addresses 0x8000–0xFFFF, active low |
| seg_rom_n | output | 1 | Enable for external program memory, active low |

## Verification
On every clock, the assertions check the following:
- no more than one enable is low;
- the strobe is low only inside a cycle;
- write data appears on the clock after a write cycle opens;
- the drive is released as a read cycle begins;
- a Y read result never appears while the core is still stalled.

The bench scenarios are the only way to show the rest:
- the address decode at each segment boundary;
- the exact cycle length for each wait field, including the reset value;
- the X-then-Y order;
- the data hold across idle clocks;
- the total stall count per instruction.

// File: rtl/emi_pkg.sv
// Shared types for the external memory interface sequencer.
// Assumes four external segments, numbered in the order of their
// wait-register fields.
package emi_pkg;
    localparam int NSEG = 4;

    typedef enum logic [1:0] {
        SEG_LO  = 2'd0,
        SEG_IO  = 2'd1,
        SEG_HI  = 2'd2,
        SEG_ROM = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XACC = 2'd1,
        ST_YACC = 2'd2
    } st_e;
endpackage

// File: rtl/emi_decode.sv
// Data-address decoder: marks addresses at or above the I/O base as
// external and names the data segment they fall in.
// Assumes IO_BASE < IO_BASE + IO_WORDS <= HI_BASE.
module emi_decode #(
    parameter int            AW       = 16,
    parameter logic [AW-1:0] IO_BASE  = 'h4000,
    parameter int            IO_WORDS = 256,
    parameter logic [AW-1:0] HI_BASE  = 'h8000
) (
    input  logic [AW-1:0] addr,
    output logic          ext,
    output emi_pkg::seg_e seg
);
    import emi_pkg::*;
    localparam logic [AW-1:0] IO_END = IO_BASE + AW'(IO_WORDS);

    // Range compare that picks the segment.
    always_comb begin
        ext = (addr >= IO_BASE);
        if (addr >= HI_BASE)
            seg = SEG_HI;
        else if (addr < IO_END)
            seg = SEG_IO;
        else
            seg = SEG_LO;
    end
endmodule

// File: rtl/emi_waitcfg.sv
// Wait register: holds one WW-bit wait field per segment and returns
// the field of the selected segment. Resets to all ones.
// Assumes the register is written only through cfg_we and cfg_wdata.
module emi_waitcfg #(
    parameter int WW = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [emi_pkg::NSEG*WW-1:0]  cfg_wdata,
    input  emi_pkg::seg_e                sel,
    output logic [WW-1:0]                wait_o
);
    import emi_pkg::*;
    localparam int RW = NSEG * WW;

    logic [RW-1:0] wait_q;

    // Register load from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wait_q <= '1;
        else if (cfg_we)
            wait_q <= cfg_wdata;
    end

    // Field select for the segment being launched.
    always_comb wait_o = wait_q[int'(sel)*WW +: WW];

    // R5
    wait_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> wait_q == $past(cfg_wdata));
endmodule

// File: rtl/emi_busdrive.sv
// Write-data drive and hold. The data bus turns on one clock after a
// write cycle opens, and it keeps the last write value until a read
// cycle is launched.
// Assumes start_rd and load_wr are never high together.
module emi_busdrive #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_rd,
    input  logic          load_wr,
    input  logic [DW-1:0] wdata,
    output logic          doe,
    output logic [DW-1:0] dout
);
    // Drive-enable and data holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            doe  <= 1'b0;
            dout <= '0;
        end else if (start_rd) begin
            doe <= 1'b0;
        end else if (load_wr) begin
            doe  <= 1'b1;
            dout <= wdata;
        end
    end

    // R8
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (doe && dout == $past(wdata)));
    // R9
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_rd |=> !doe);
endmodule

// File: rtl/emi_sequencer.sv
// External memory interface sequencer. It serialises the X and Y port
// requests of one instruction onto a shared external bus, X first. It
// stretches each cycle by the segment's wait count and stalls the core
// until the last access is done. Assumes the core holds its request
// inputs steady while stall is high and changes them before the clock
// edge that follows a low stall.
module emi_sequencer #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int WW = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [emi_pkg::NSEG*WW-1:0]   cfg_wdata,
    input  logic                          x_req,
    input  logic                          x_we,
    input  logic [AW-1:0]                 x_addr,
    input  logic [DW-1:0]                 x_wdata,
    input  logic                          y_req,
    input  logic                          y_we,
    input  logic [AW-1:0]                 y_addr,
    input  logic [DW-1:0]                 y_wdata,
    output logic                          stall,
    output logic [DW-1:0]                 rd_data,
    output logic                          x_rvalid,
    output logic                          y_rvalid,
    output logic [AW-1:0]                 ext_addr,
    output logic [DW-1:0]                 ext_dout,
    output logic                          ext_doe,
    input  logic [DW-1:0]                 ext_din,
    output logic                          ext_rwn,
    output logic                          seg_lo_n,
    output logic                          seg_io_n,
    output logic                          seg_hi_n,
    output logic                          seg_rom_n
);
    import emi_pkg::*;
    localparam int CW = WW + 1;

    st_e           state;
    logic [CW-1:0] ph, lim;
    logic          cur_we;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_wdata;
    seg_e          cur_seg;
    logic          pend_y, py_we;
    logic [AW-1:0] py_addr;
    logic [DW-1:0] py_wdata;
    seg_e          py_seg;

    logic          y_hit, y_ext;
    seg_e          y_dseg;
    logic          active, at_end, last, idle_go, chain, launch;
    logic          l_we;
    logic [AW-1:0] l_addr;
    logic [DW-1:0] l_wdata;
    seg_e          l_seg;
    logic [WW-1:0] l_wait;
    logic [NSEG-1:0] seg_n;

    emi_decode #(.AW(AW)) u_dec (
        .addr (y_addr),
        .ext  (y_hit),
        .seg  (y_dseg)
    );

    emi_waitcfg #(.WW(WW)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .sel       (l_seg),
        .wait_o    (l_wait)
    );

    // Cycle position and launch conditions.
    always_comb begin
        y_ext   = y_req && y_hit;
        active  = (state != ST_IDLE);
        at_end  = active && (ph == lim);
        last    = at_end && ((state == ST_YACC) || !pend_y);
        idle_go = (state == ST_IDLE) && (x_req || y_ext);
        chain   = (state == ST_XACC) && at_end && pend_y;
        launch  = idle_go || chain;
        stall   = (state == ST_IDLE) ? (x_req || y_ext) : !last;
    end

    // Pick the access to launch: a queued Y, else X, else a new Y.
    always_comb begin
        if (chain) begin
            l_we = py_we; l_addr = py_addr; l_wdata = py_wdata; l_seg = py_seg;
        end else if (x_req) begin
            l_we = x_we; l_addr = x_addr; l_wdata = x_wdata; l_seg = SEG_ROM;
        end else begin
            l_we = y_we; l_addr = y_addr; l_wdata = y_wdata; l_seg = y_dseg;
        end
    end

    // Sequencer state, phase counter and latched accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ph        <= '0;
            lim       <= '0;
            cur_we    <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_seg   <= SEG_LO;
            pend_y    <= 1'b0;
            py_we     <= 1'b0;
            py_addr   <= '0;
            py_wdata  <= '0;
            py_seg    <= SEG_LO;
        end else if (launch) begin
            state     <= (idle_go && x_req) ? ST_XACC : ST_YACC;
            ph        <= '0;
            lim       <= {1'b0, l_wait} + CW'(1);
            cur_we    <= l_we;
            cur_addr  <= l_addr;
            cur_wdata <= l_wdata;
            cur_seg   <= l_seg;
            if (idle_go) begin
                pend_y   <= x_req && y_ext;
                py_we    <= y_we;
                py_addr  <= y_addr;
                py_wdata <= y_wdata;
                py_seg   <= y_dseg;
            end else begin
                pend_y <= 1'b0;
            end
        end else if (at_end) begin
            state <= ST_IDLE;
        end else if (active) begin
            ph <= ph + CW'(1);
        end
    end

    // Read capture on the last clock and per-port valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            x_rvalid <= 1'b0;
            y_rvalid <= 1'b0;
        end else begin
            x_rvalid <= at_end && !cur_we && (state == ST_XACC);
            y_rvalid <= at_end && !cur_we && (state == ST_YACC);
            if (at_end && !cur_we)
                rd_data <= ext_din;
        end
    end

    emi_busdrive #(.DW(DW)) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_rd (launch && !l_we),
        .load_wr  (active && cur_we && (ph == '0)),
        .wdata    (cur_wdata),
        .doe      (ext_doe),
        .dout     (ext_dout)
    );

    // One active-low enable per segment.
    for (genvar g = 0; g < NSEG; g++) begin : g_en
        assign seg_n[g] = !(active && (int'(cur_seg) == g));
    end

    assign seg_lo_n  = seg_n[SEG_LO];
    assign seg_io_n  = seg_n[SEG_IO];
    assign seg_hi_n  = seg_n[SEG_HI];
    assign seg_rom_n = seg_n[SEG_ROM];
    assign ext_addr  = cur_addr;
    assign ext_rwn   = !(active && cur_we);

    // R12
    one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~seg_n) <= 1);
    // R7
    rwn_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rwn |-> (seg_n != '1));
    // R10
    stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_rvalid |-> !$past(stall));
endmodule

// File: tb/sim_emi_sequencer.sv
// Scoreboard bench: the driver pushes the expected bus cycles and reads,
// and the monitors pop and compare them as the design produces them.
module sim_emi_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        x_req = 1'b0, x_we = 1'b0, y_req = 1'b0, y_we = 1'b0;
    logic [15:0] x_addr = '0, x_wdata = '0, y_addr = '0, y_wdata = '0;
    logic        stall, x_rvalid, y_rvalid, ext_doe, ext_rwn;
    logic        seg_lo_n, seg_io_n, seg_hi_n, seg_rom_n;
    logic [15:0] rd_data, ext_addr, ext_dout, ext_din;

    localparam logic [15:0] KEY = 16'h5A3C;
    assign ext_din = ext_addr ^ KEY;

    always #4 clk = ~clk;

    emi_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .x_req(x_req), .x_we(x_we), .x_addr(x_addr), .x_wdata(x_wdata),
        .y_req(y_req), .y_we(y_we), .y_addr(y_addr), .y_wdata(y_wdata),
        .stall(stall), .rd_data(rd_data), .x_rvalid(x_rvalid), .y_rvalid(y_rvalid),
        .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe), .ext_din(ext_din),
        .ext_rwn(ext_rwn), .seg_lo_n(seg_lo_n), .seg_io_n(seg_io_n),
        .seg_hi_n(seg_hi_n), .seg_rom_n(seg_rom_n)
    );

    typedef struct { int seg; bit we; logic [15:0] addr; logic [15:0] data; int len; } bus_t;
    typedef struct { bit port; logic [15:0] data; } rd_t;
    bus_t bus_q[$];
    rd_t  rd_q[$];
    int   waits[4] = '{15, 15, 15, 15};
    int   tests = 0, fails = 0;
    bit   done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int seg_of(input logic [15:0] a);
        if (a >= 16'h8000) return 2;
        if (a <= 16'h40FF) return 1;
        return 0;
    endfunction

    task automatic set_waits(input int lo, input int io, input int hi, input int rom);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = {rom[3:0], hi[3:0], io[3:0], lo[3:0]};
        @(negedge clk);
        cfg_we = 1'b0;
        waits = '{lo, io, hi, rom};
    endtask

    // Driver: one instruction on both ports, with the expected stall count.
    task automatic instr(input bit xr, input bit xw, input logic [15:0] xa, input logic [15:0] xd,
                         input bit yr, input bit yw, input logic [15:0] ya, input logic [15:0] yd);
        int exp_n = 0;
        int n = 0;
        bus_t b;
        if (xr) begin
            b = '{3, xw, xa, xd, waits[3] + 2};
            bus_q.push_back(b);
            exp_n += b.len;
            if (!xw) rd_q.push_back('{1'b0, xa ^ KEY});
        end
        if (yr && ya >= 16'h4000) begin
            b = '{seg_of(ya), yw, ya, yd, waits[seg_of(ya)] + 2};
            bus_q.push_back(b);
            exp_n += b.len;
            if (!yw) rd_q.push_back('{1'b1, ya ^ KEY});
        end
        @(negedge clk);
        x_req = xr; x_we = xw; x_addr = xa; x_wdata = xd;
        y_req = yr; y_we = yw; y_addr = ya; y_wdata = yd;
        #1;
        while (stall && n < 100) begin
            n++;
            @(negedge clk);
            #1;
        end
        x_req = 1'b0; y_req = 1'b0;
        // R10 and R3: stalled clocks equal the sum of the cycle lengths
        check(n == exp_n, "R10/R3 stall count", n, exp_n);
    endtask

    // Monitor for external bus cycles.
    bit   in_cyc = 0;
    int   clen = 0;
    bus_t cur;
    logic [3:0]  cur_en;
    logic [15:0] cur_a;
    always @(negedge clk) begin
        logic [3:0] en;
        en = {seg_rom_n, seg_hi_n, seg_io_n, seg_lo_n};
        if (rst_n && !done) begin
            // R12: never more than one enable low
            check($countones(~en) <= 1, "R12 enables", en, 0);
            if (in_cyc && (en == 4'hF || en != cur_en || ext_addr != cur_a)) begin
                // R5: cycle length is 2 + wait field
                check(clen == cur.len, "R5 cycle length", clen, cur.len);
                in_cyc = 0;
            end
            if (en != 4'hF && !in_cyc) begin
                if (bus_q.size() == 0) begin
                    // R3: no unexpected external cycle
                    check(0, "R3 unexpected cycle", ext_addr, 0);
                    cur = '{0, 0, ext_addr, 0, 0};
                end else begin
                    cur = bus_q.pop_front();
                    // R2, R4, R6: segment, address and order
                    check(en == ~(4'b1 << cur.seg), "R2/R4/R6 segment", en, ~(4'b1 << cur.seg));
                    check(ext_addr == cur.addr, "R2/R6 address", ext_addr, cur.addr);
                end
                in_cyc = 1; clen = 0; cur_en = en; cur_a = ext_addr;
            end
            if (en != 4'hF) begin
                clen++;
                // R7: strobe low for the whole write cycle
                check(ext_rwn == !cur.we, "R7 rwn", ext_rwn, !cur.we);
                if (cur.we && clen == 2)
                    check(ext_doe && ext_dout == cur.data, "R8 write drive", ext_dout, cur.data);
                if (!cur.we)
                    check(!ext_doe, "R9 read release", ext_doe, 0);
            end else begin
                check(ext_rwn, "R7 rwn idle", ext_rwn, 1);
            end
        end
    end

    // Monitor for returned read data.
    always @(negedge clk) begin
        rd_t r;
        if (rst_n && !done && (x_rvalid || y_rvalid)) begin
            if (rd_q.size() == 0) begin
                check(0, "R11 unexpected read", rd_data, 0);
            end else begin
                r = rd_q.pop_front();
                check(x_rvalid != y_rvalid && y_rvalid == r.port, "R11 read port", y_rvalid, r.port);
                check(rd_data == r.data, "R11 read data", rd_data, r.data);
            end
        end
    end

    task automatic idle_hold(input bit exp_doe, input logic [15:0] exp_d, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            #1;
            check(ext_doe == exp_doe, "R9 hold enable", ext_doe, exp_doe);
            if (exp_doe) check(ext_dout == exp_d, "R9 hold data", ext_dout, exp_d);
            check({seg_rom_n, seg_hi_n, seg_io_n, seg_lo_n} == 4'hF, "R12 idle enables",
                  {seg_rom_n, seg_hi_n, seg_io_n, seg_lo_n}, 4'hF);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        tests++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check({seg_rom_n, seg_hi_n, seg_io_n, seg_lo_n} == 4'hF, "R1 enables",
              {seg_rom_n, seg_hi_n, seg_io_n, seg_lo_n}, 4'hF);
        check(ext_rwn && !ext_doe && !stall, "R1 strobe/drive/stall",
              {ext_rwn, ext_doe, stall}, 3'b100);
        // R1 and R5: reset wait register gives 17-clock cycles
        instr(1, 0, 16'h1234, 0, 0, 0, 0, 0);
        instr(0, 0, 0, 0, 1, 0, 16'h9000, 0);
        set_waits(1, 0, 3, 2);
        // R2: segment boundaries
        instr(0, 0, 0, 0, 1, 0, 16'h4000, 0);
        instr(0, 0, 0, 0, 1, 0, 16'h40FF, 0);
        instr(0, 0, 0, 0, 1, 0, 16'h4100, 0);
        instr(0, 0, 0, 0, 1, 0, 16'h7FFF, 0);
        instr(0, 0, 0, 0, 1, 0, 16'h8000, 0);
        instr(0, 0, 0, 0, 1, 0, 16'hFFFF, 0);
        // R3: internal and reserved addresses
        instr(0, 0, 0, 0, 1, 0, 16'h0000, 0);
        instr(0, 0, 0, 0, 1, 1, 16'h17FF, 16'h1111);
        instr(0, 0, 0, 0, 1, 0, 16'h3FFF, 0);
        idle_hold(0, 0, 3);
        // R4: X plus internal Y gives only the X cycle
        instr(1, 0, 16'h0042, 0, 1, 0, 16'h0100, 0);
        // R8, R9: write then hold across idle clocks
        instr(0, 0, 0, 0, 1, 1, 16'h4123, 16'hBEEF);
        idle_hold(1, 16'hBEEF, 3);
        // R6: both ports, X first
        instr(1, 0, 16'h0200, 0, 1, 0, 16'h8010, 0);
        // R9: X write then Y read releases the bus
        instr(1, 1, 16'h0300, 16'hCAFE, 1, 0, 16'h4010, 0);
        idle_hold(0, 0, 2);
        // R6, R8: X read then Y write
        instr(1, 0, 16'h0400, 0, 1, 1, 16'h5555, 16'h1357);
        idle_hold(1, 16'h1357, 2);
        // R9: write then write keeps driving
        instr(1, 1, 16'h0500, 16'hA1A1, 0, 0, 0, 0);
        instr(0, 0, 0, 0, 1, 1, 16'hC000, 16'h7E7E);
        idle_hold(1, 16'h7E7E, 2);
        // R5: zero waits and one field at maximum
        set_waits(0, 15, 0, 0);
        instr(1, 1, 16'h0600, 16'h0F0F, 1, 1, 16'h4080, 16'hF0F0);
        instr(1, 0, 16'h0700, 0, 1, 0, 16'h6000, 0);
        instr(0, 0, 0, 0, 1, 0, 16'h8888, 0);
        repeat (4) @(negedge clk);
        #1;
        // R11: every expected cycle and read was seen
        check(bus_q.size() == 0 && rd_q.size() == 0, "R11 queues drained",
              bus_q.size() + rd_q.size(), 0);
        finish_run();
    end
endmodule